// File: doc/BRIEF.md
# Sequentially Consistent Memory Access Issuer

This block takes one processor's in-order stream of loads and stores and passes them to an invalidation-based cached memory system one at a time. Each access is held back until the one before it has fully completed, so every other agent observes this processor's accesses in program order and each store appears atomic. A store is complete when the cache reports that the block was already held dirty, or when every invalidation acknowledgement the store caused has been collected. A load is complete when its data has come back and the store that wrote that data is itself complete.

The controller is a five-state machine. IDLE accepts a request (IDLE to ISSUE on a handshake). ISSUE presents the request to memory for exactly one cycle and moves to WAIT_LOAD for a load or WAIT_ACKS for a store. WAIT_LOAD moves to DONE on a response that carries the source-store-complete flag. WAIT_ACKS moves to DONE on a dirty-hit response, or once the outstanding acknowledgement count reaches zero. DONE returns load data or signals store commit for one cycle and always goes back to IDLE. The store commit pulse is the point at which the written value may be released to other agents.

Acknowledgements are counted by a wrapping counter: each pulse seen while waiting on a store subtracts one, and the expected count from the cache response is added once. An acknowledgement in the same cycle as the response, or before it, is therefore never lost.

Top module: `sc_issue_ctrl`

## Requirements
- R1: After reset, req_ready is 1 and busy, mem_valid, ld_valid and st_commit are 0.
- R2: req_ready is 1 only in IDLE; while an access is in flight req_ready is 0 and busy is 1.
- R3: One cycle after a request is accepted, mem_valid is 1 for exactly one cycle with mem_store, mem_addr and mem_wdata equal to the accepted request (mem_store 1 = store, 0 = load); requests reach memory in acceptance order.
- R4: While an access is in flight, no further mem_valid is produced even if req_valid is held high.
- R5: A load completes only on a cycle with rsp_valid and rsp_src_done both 1; in the next cycle ld_valid is 1 for one cycle with ld_data equal to rsp_rdata of that cycle. Responses with rsp_src_done 0 are not accepted.
- R6: A store whose response has rsp_dirty 0 commits (st_commit 1 for one cycle) in the cycle after the cycle in which the number of inv_ack pulses received equals rsp_ack_cnt, and not before.
- R7: An inv_ack in the same cycle as the store response counts toward that store.
- R8: A store response with rsp_dirty 1 commits in the next cycle, ignoring rsp_ack_cnt.
- R9: An inv_ack that arrives after a store is issued but before its response counts toward that store.
- R10: inv_ack pulses while no store is waiting have no effect on any later store.
- R11: The cycle after ld_valid or st_commit, req_ready is 1 again.
- R12: A store with rsp_dirty 0 and rsp_ack_cnt 0 commits in the cycle after its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Store data |
| mem_valid | output | 1 | Access issued to memory (one cycle) |
| mem_store | output | 1 | Issued access is a store |
| mem_addr | output | AW | Issued address |
| mem_wdata | output | DW | Issued store data |
| rsp_valid | input | 1 | Cache response present |
| rsp_dirty | input | 1 | Store hit a block held dirty |
| rsp_src_done | input | 1 | Store that produced load data is complete |
| rsp_ack_cnt | input | CW | Invalidation acknowledgements expected |
| rsp_rdata | input | DW | Load data |
| inv_ack | input | 1 | One invalidation acknowledgement |
| ld_valid | output | 1 | Load data returned (one cycle) |
| ld_data | output | DW | Returned load data |
| st_commit | output | 1 | Store complete, value may be released |
| busy | output | 1 | An access is in flight |

## Verification
An accepted request shows on the memory side one cycle after the accepting edge, and ld_valid or st_commit appears one cycle after the cycle holding the completing response or last acknowledgement; req_ready returns one cycle after that. The bench drives inputs and samples outputs on the falling edge, so each check lands in the exact cycle its requirement names and also confirms the output was still low one cycle earlier. Acknowledgement timing is varied across before, with and after the response, and held requests probe that nothing slips out early.

// File: rtl/sc_issue_pkg.sv
package sc_issue_pkg;

    typedef enum logic [2:0] {
        IDLE      = 3'd0,
        ISSUE     = 3'd1,
        WAIT_LOAD = 3'd2,
        WAIT_ACKS = 3'd3,
        DONE      = 3'd4
    } sc_state_t;

endpackage

// File: rtl/sc_xfer_regs.sv
module sc_xfer_regs #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture_req,
    input  logic          in_store,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_wdata,
    input  logic          capture_ld,
    input  logic [DW-1:0] in_rdata,
    output logic          hold_store,
    output logic [AW-1:0] hold_addr,
    output logic [DW-1:0] hold_wdata,
    output logic [DW-1:0] hold_rdata
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_store <= 1'b0;
            hold_addr  <= '0;
            hold_wdata <= '0;
        end else if (capture_req) begin
            hold_store <= in_store;
            hold_addr  <= in_addr;
            hold_wdata <= in_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_rdata <= '0;
        end else if (capture_ld) begin
            hold_rdata <= in_rdata;
        end
    end

endmodule

// File: rtl/sc_ack_tracker.sv
module sc_ack_tracker #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          count_en,
    input  logic          ack,
    input  logic          load_en,
    input  logic [CW-1:0] load_val,
    output logic          loaded,
    output logic          done_now
);

    logic [CW-1:0] remain;
    logic [CW-1:0] remain_nxt;
    logic [CW-1:0] ack_step;

    assign ack_step = {{(CW-1){1'b0}}, count_en & ack};

    always_comb begin
        if (load_en) begin
            remain_nxt = remain + load_val - ack_step;
        end else begin
            remain_nxt = remain - ack_step;
        end
        done_now = (loaded | load_en) && (remain_nxt == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            remain <= '0;
            loaded <= 1'b0;
        end else begin
            remain <= remain_nxt;
            if (load_en) begin
                loaded <= 1'b1;
            end
        end
    end

    // R6: the expected count is taken once per store
    a_r6_single_load: assert property (@(posedge clk) disable iff (!rst_n)
        loaded |-> !load_en);

    // R7: an ack with a count of one in the same cycle finishes the store
    a_r7_same_cycle_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && count_en && ack && !loaded && remain == '0 && load_val == CW'(1)) |-> done_now);

endmodule

// File: rtl/sc_issue_fsm.sv
module sc_issue_fsm
    import sc_issue_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic hold_store,
    input  logic rsp_valid,
    input  logic rsp_dirty,
    input  logic rsp_src_done,
    input  logic trk_loaded,
    input  logic trk_done,
    output logic req_ready,
    output logic busy,
    output logic mem_valid,
    output logic ld_valid,
    output logic st_commit,
    output logic capture_req,
    output logic capture_ld,
    output logic trk_clr,
    output logic trk_count_en,
    output logic trk_load
);

    sc_state_t state;
    sc_state_t state_nxt;
    logic      first_rsp;

    assign first_rsp = rsp_valid && !trk_loaded;

    always_comb begin
        state_nxt = state;
        unique case (state)
            IDLE:      if (req_valid) state_nxt = ISSUE;
            ISSUE:     state_nxt = hold_store ? WAIT_ACKS : WAIT_LOAD;
            WAIT_LOAD: if (rsp_valid && rsp_src_done) state_nxt = DONE;
            WAIT_ACKS: begin
                if (first_rsp && rsp_dirty) begin
                    state_nxt = DONE;
                end else if (trk_done) begin
                    state_nxt = DONE;
                end
            end
            DONE:      state_nxt = IDLE;
            default:   state_nxt = IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        req_ready    = 1'b0;
        busy         = 1'b1;
        mem_valid    = 1'b0;
        ld_valid     = 1'b0;
        st_commit    = 1'b0;
        capture_req  = 1'b0;
        capture_ld   = 1'b0;
        trk_clr      = 1'b0;
        trk_count_en = 1'b0;
        trk_load     = 1'b0;
        unique case (state)
            IDLE: begin
                req_ready   = 1'b1;
                busy        = 1'b0;
                capture_req = req_valid;
            end
            ISSUE: begin
                mem_valid = 1'b1;
                trk_clr   = 1'b1;
            end
            WAIT_LOAD: begin
                capture_ld = rsp_valid && rsp_src_done;
            end
            WAIT_ACKS: begin
                trk_count_en = 1'b1;
                trk_load     = first_rsp && !rsp_dirty;
            end
            DONE: begin
                ld_valid  = !hold_store;
                st_commit = hold_store;
            end
            default: begin
                busy = 1'b1;
            end
        endcase
    end

    // R5: load data only follows a response whose source store is complete
    a_r5_load_needs_src: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(rsp_valid && rsp_src_done));

    // R8: a dirty hit finishes without waiting for acknowledgements
    a_r8_dirty_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WAIT_ACKS && first_rsp && rsp_dirty) |=> st_commit);

    // R6: a commit is preceded by the last ack or a dirty hit
    a_r6_commit_cause: assert property (@(posedge clk) disable iff (!rst_n)
        st_commit |-> $past(trk_done || (rsp_valid && rsp_dirty)));

    // R11: completion hands control straight back to the processor
    a_r11_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid || st_commit) |=> req_ready);

endmodule

// File: rtl/sc_issue_ctrl.sv
module sc_issue_ctrl #(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_store,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          mem_valid,
    output logic          mem_store,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          rsp_valid,
    input  logic          rsp_dirty,
    input  logic          rsp_src_done,
    input  logic [CW-1:0] rsp_ack_cnt,
    input  logic [DW-1:0] rsp_rdata,
    input  logic          inv_ack,
    output logic          ld_valid,
    output logic [DW-1:0] ld_data,
    output logic          st_commit,
    output logic          busy
);

    logic capture_req;
    logic capture_ld;
    logic trk_clr;
    logic trk_count_en;
    logic trk_load;
    logic trk_loaded;
    logic trk_done;
    logic hold_store;

    sc_xfer_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_req(capture_req),
        .in_store   (req_store),
        .in_addr    (req_addr),
        .in_wdata   (req_wdata),
        .capture_ld (capture_ld),
        .in_rdata   (rsp_rdata),
        .hold_store (hold_store),
        .hold_addr  (mem_addr),
        .hold_wdata (mem_wdata),
        .hold_rdata (ld_data)
    );

    sc_ack_tracker #(.CW(CW)) u_acks (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (trk_clr),
        .count_en(trk_count_en),
        .ack     (inv_ack),
        .load_en (trk_load),
        .load_val(rsp_ack_cnt),
        .loaded  (trk_loaded),
        .done_now(trk_done)
    );

    sc_issue_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .hold_store  (hold_store),
        .rsp_valid   (rsp_valid),
        .rsp_dirty   (rsp_dirty),
        .rsp_src_done(rsp_src_done),
        .trk_loaded  (trk_loaded),
        .trk_done    (trk_done),
        .req_ready   (req_ready),
        .busy        (busy),
        .mem_valid   (mem_valid),
        .ld_valid    (ld_valid),
        .st_commit   (st_commit),
        .capture_req (capture_req),
        .capture_ld  (capture_ld),
        .trk_clr     (trk_clr),
        .trk_count_en(trk_count_en),
        .trk_load    (trk_load)
    );

    assign mem_store = hold_store;

    // R3: an accepted request is the next one presented to memory
    a_r3_issue_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_valid && mem_addr == $past(req_addr)
                                      && mem_store == $past(req_store)));

    // R4: an issue never repeats in back-to-back cycles
    a_r4_one_issue: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |=> !mem_valid);

    // R2: ready and busy are never both high
    a_r2_ready_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && busy));

endmodule

// File: tb/sc_issue_ctrl_bench.sv
module sc_issue_ctrl_bench;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_ready, req_store;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          mem_valid, mem_store;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          rsp_valid, rsp_dirty, rsp_src_done;
    logic [CW-1:0] rsp_ack_cnt;
    logic [DW-1:0] rsp_rdata;
    logic          inv_ack;
    logic          ld_valid, st_commit, busy;
    logic [DW-1:0] ld_data;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    sc_issue_ctrl #(.AW(AW), .DW(DW), .CW(CW)) u_sc_issue_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .mem_valid(mem_valid), .mem_store(mem_store), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .rsp_valid(rsp_valid), .rsp_dirty(rsp_dirty), .rsp_src_done(rsp_src_done),
        .rsp_ack_cnt(rsp_ack_cnt), .rsp_rdata(rsp_rdata), .inv_ack(inv_ack),
        .ld_valid(ld_valid), .ld_data(ld_data), .st_commit(st_commit), .busy(busy)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 20000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic chk_word(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic quiet_inputs;
        req_valid = 1'b0; req_store = 1'b0; req_addr = '0; req_wdata = '0;
        rsp_valid = 1'b0; rsp_dirty = 1'b0; rsp_src_done = 1'b0;
        rsp_ack_cnt = '0; rsp_rdata = '0; inv_ack = 1'b0;
    endtask

    // Starts at a falling edge in IDLE, ends at the falling edge of the first wait cycle
    task automatic send_req(input logic st, input logic [AW-1:0] a, input logic [DW-1:0] d);
        chk_bit("R2 ready in idle", req_ready, 1'b1);
        req_valid = 1'b1; req_store = st; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk_bit("R3 issue valid", mem_valid, 1'b1);
        chk_bit("R3 issue op", mem_store, st);
        chk_word("R3 issue addr", 32'(mem_addr), 32'(a));
        if (st) chk_word("R3 issue wdata", mem_wdata, d);
        chk_bit("R2 ready low in flight", req_ready, 1'b0);
        chk_bit("R2 busy in flight", busy, 1'b1);
        @(negedge clk);
        chk_bit("R3 issue lasts one cycle", mem_valid, 1'b0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        quiet_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_bit("R1 ready", req_ready, 1'b1);
        chk_bit("R1 busy", busy, 1'b0);
        chk_bit("R1 mem_valid", mem_valid, 1'b0);
        chk_bit("R1 ld_valid", ld_valid, 1'b0);
        chk_bit("R1 st_commit", st_commit, 1'b0);
    endtask

    task automatic t_load_basic;
        send_req(1'b0, 16'h0100, '0);
        rsp_valid = 1'b1; rsp_src_done = 1'b1; rsp_rdata = 32'hCAFE_0001;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_src_done = 1'b0;
        chk_bit("R5 load returns", ld_valid, 1'b1);
        chk_word("R5 load data", ld_data, 32'hCAFE_0001);
        chk_bit("R5 no commit on load", st_commit, 1'b0);
        @(negedge clk);
        chk_bit("R5 ld_valid one cycle", ld_valid, 1'b0);
        chk_bit("R11 ready after load", req_ready, 1'b1);
    endtask

    task automatic t_load_src_wait;
        send_req(1'b0, 16'h0204, '0);
        rsp_valid = 1'b1; rsp_src_done = 1'b0; rsp_rdata = 32'hDEAD_DEAD;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk_bit("R5 held while source store open", ld_valid, 1'b0);
            chk_bit("R5 still busy", busy, 1'b1);
        end
        rsp_src_done = 1'b1; rsp_rdata = 32'h1234_5678;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_src_done = 1'b0;
        chk_bit("R5 returns after source done", ld_valid, 1'b1);
        chk_word("R5 data from accepted rsp", ld_data, 32'h1234_5678);
        @(negedge clk);
        chk_bit("R11 ready", req_ready, 1'b1);
    endtask

    task automatic t_store_dirty;
        send_req(1'b1, 16'h0308, 32'hAAAA_5555);
        rsp_valid = 1'b1; rsp_dirty = 1'b1; rsp_ack_cnt = 4'd5;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_dirty = 1'b0; rsp_ack_cnt = '0;
        chk_bit("R8 dirty hit commits", st_commit, 1'b1);
        chk_bit("R8 no load return", ld_valid, 1'b0);
        @(negedge clk);
        chk_bit("R11 ready after store", req_ready, 1'b1);
        chk_bit("R8 commit one cycle", st_commit, 1'b0);
    endtask

    task automatic t_store_acks;
        send_req(1'b1, 16'h0410, 32'h0000_0042);
        rsp_valid = 1'b1; rsp_ack_cnt = 4'd3;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_ack_cnt = '0;
        chk_bit("R6 wait 3 acks (0 seen)", st_commit, 1'b0);
        inv_ack = 1'b1;
        @(negedge clk);
        inv_ack = 1'b0;
        chk_bit("R6 wait (1 seen)", st_commit, 1'b0);
        @(negedge clk);
        chk_bit("R6 wait (1 seen, gap)", st_commit, 1'b0);
        inv_ack = 1'b1;
        @(negedge clk);
        chk_bit("R6 wait (2 seen)", st_commit, 1'b0);
        chk_bit("R2 busy while acks open", busy, 1'b1);
        @(negedge clk);
        inv_ack = 1'b0;
        chk_bit("R6 commit after last ack", st_commit, 1'b1);
        @(negedge clk);
        chk_bit("R11 ready", req_ready, 1'b1);
    endtask

    task automatic t_store_same_cycle;
        send_req(1'b1, 16'h0520, 32'h0000_0007);
        rsp_valid = 1'b1; rsp_ack_cnt = 4'd1; inv_ack = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_ack_cnt = '0; inv_ack = 1'b0;
        chk_bit("R7 same-cycle ack counted", st_commit, 1'b1);
        @(negedge clk);
        chk_bit("R11 ready", req_ready, 1'b1);
    endtask

    task automatic t_store_zero;
        send_req(1'b1, 16'h0624, 32'h0000_0009);
        rsp_valid = 1'b1; rsp_ack_cnt = 4'd0;
        @(negedge clk);
        rsp_valid = 1'b0;
        chk_bit("R12 zero count commits", st_commit, 1'b1);
        @(negedge clk);
        chk_bit("R11 ready", req_ready, 1'b1);
    endtask

    task automatic t_store_early;
        send_req(1'b1, 16'h0730, 32'h0000_0011);
        inv_ack = 1'b1;
        @(negedge clk);
        inv_ack = 1'b0;
        rsp_valid = 1'b1; rsp_ack_cnt = 4'd2;
        chk_bit("R9 early ack no commit", st_commit, 1'b0);
        @(negedge clk);
        rsp_valid = 1'b0; rsp_ack_cnt = '0;
        chk_bit("R9 one ack left", st_commit, 1'b0);
        inv_ack = 1'b1;
        @(negedge clk);
        inv_ack = 1'b0;
        chk_bit("R9 early ack counted", st_commit, 1'b1);
        @(negedge clk);
        chk_bit("R11 ready", req_ready, 1'b1);
    endtask

    task automatic t_stray_acks;
        inv_ack = 1'b1;
        repeat (2) @(negedge clk);
        inv_ack = 1'b0;
        send_req(1'b1, 16'h0840, 32'h0000_0013);
        rsp_valid = 1'b1; rsp_ack_cnt = 4'd1;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_ack_cnt = '0;
        chk_bit("R10 idle acks ignored", st_commit, 1'b0);
        inv_ack = 1'b1;
        @(negedge clk);
        inv_ack = 1'b0;
        chk_bit("R10 own ack commits", st_commit, 1'b1);
        @(negedge clk);
        chk_bit("R11 ready", req_ready, 1'b1);
    endtask

    task automatic t_order;
        send_req(1'b0, 16'h0A00, '0);
        req_valid = 1'b1; req_store = 1'b1; req_addr = 16'h0B00; req_wdata = 32'h0000_00BB;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk_bit("R4 no second issue", mem_valid, 1'b0);
            chk_bit("R4 held off", req_ready, 1'b0);
        end
        rsp_valid = 1'b1; rsp_src_done = 1'b1; rsp_rdata = 32'h0000_00AA;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_src_done = 1'b0;
        chk_bit("R4 first completes", ld_valid, 1'b1);
        chk_bit("R4 no issue in done", mem_valid, 1'b0);
        @(negedge clk);
        chk_bit("R11 ready", req_ready, 1'b1);
        @(negedge clk);
        req_valid = 1'b0;
        chk_bit("R3 second issued", mem_valid, 1'b1);
        chk_word("R3 second addr in order", 32'(mem_addr), 32'h0000_0B00);
        chk_bit("R3 second op", mem_store, 1'b1);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_dirty = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_dirty = 1'b0;
        chk_bit("R8 second commits", st_commit, 1'b1);
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_load_basic();
        t_load_src_wait();
        t_store_dirty();
        t_store_acks();
        t_store_same_cycle();
        t_store_zero();
        t_store_early();
        t_stray_acks();
        t_order();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule